// File: doc/BRIEF.md
# Auto-Incrementing RGB Palette DAC Port

This block holds a color lookup table of 256 entries. Each entry has a red, a green and a blue channel of 6 bits. A host reaches the table through one byte-wide port, and a 2-bit select picks one of four registers on that port: a write index, a read index, a data register and a pixel mask. Each entry is 18 bits, too wide for one byte, so every data access moves one channel. A channel counter steps red, green, blue and back to red. When the counter returns to red, the index that belongs to the access advances by one, so a host can stream a whole table as a run of bytes.

The block also tracks a direction state. Loading the write index selects write mode and loading the read index selects read mode. A data access in the opposite mode still steps the channel counter, but it moves no color. A display pipeline reads the table through a separate lookup port. The pixel index is ANDed with the mask register, and the color appears one clock later.

Two enumerated state machines sit in the sequencer:
- Channel states: `CH_RED`, `CH_GREEN`, `CH_BLUE`. Transitions: step (any data access, red to green to blue to red), and rewind (any index load, back to red).
- Direction states: `DIR_WRITE`, `DIR_READ`. Transitions: enter-write (write-index load) and enter-read (read-index load).

Top module: `clut_port`

## Requirements
- R1: A host write with `host_sel`=0 loads the write index from the byte, sets direction to write and rewinds the channel to red.
- R2: A host write with `host_sel`=1 loads the read index from the byte, sets direction to read and rewinds the channel to red.
- R3: A host read with `host_sel`=0 returns the write index and with `host_sel`=1 the read index. Neither read changes the channel or the direction.
- R4: A host write with `host_sel`=2 in write direction stores bits 5:0 of the byte into the current channel of the write-index entry. The other two channels of that entry keep their values.
- R5: A host read with `host_sel`=2 in read direction returns the current channel of the read-index entry, zero-extended to 8 bits.
- R6: Every data access (`host_sel`=2) steps the channel red to green to blue to red. On the step from blue to red, the write index (for a write) or the read index (for a read) increments modulo 256.
- R7: A data access against the current direction still steps the channel and index as in R6. Such a write stores nothing, and such a read returns 0x00.
- R8: `host_sel`=3 selects the pixel mask, a plain read/write byte that resets to 0xFF.
- R9: `pix_rgb` shows, one clock after `pix_idx` is presented, the entry at (`pix_idx` AND mask), packed as blue[17:12], green[11:6], red[5:0].
- R10: After reset the channel is red, the direction is write, both indices are 0, every entry is 0, and `host_rdata` is 0 whenever no read is asserted. When no host strobe is asserted, the channel, direction and indices hold.
- R11: When `host_wr` and `host_rd` are both high, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe, one access per cycle |
| host_sel | input | 2 | Register select: 0 write index, 1 read index, 2 data, 3 pixel mask |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the cycle `host_rd` is high |
| pix_idx | input | 8 | Pixel lookup index |
| pix_rgb | output | 18 | Looked-up color, one cycle after `pix_idx` |

## Verification
The bench first streams all 768 channel bytes into the table. The written bytes carry nonzero upper bits, so a design that drops the 6-bit truncation, or that misses the index wrap from 255 to 0, leaves a wrong value behind. Reading the table back in full catches a channel order or an increment that fires on the wrong step. The bench reads an index register between two data reads; if that read disturbs the counter, the read lands on the wrong channel. A write of a single channel followed by a full readback exposes a write that clobbers the whole entry. Accesses against the current direction test two things: that the counter still steps, and that nothing leaks into the table. The bench then sweeps the pixel port under two masks, which shows whether the mask is applied and whether the lookup has the stated latency.

// File: rtl/clut_pkg.sv
package clut_pkg;
    localparam int DBUS_W = 8;
    localparam int CH_W   = 6;
    localparam int NCH    = 3;

    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } chan_e;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    localparam logic [1:0] SEL_WIDX = 2'd0;
    localparam logic [1:0] SEL_RIDX = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_MASK = 2'd3;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_widx,
    input  logic             ld_ridx,
    input  logic [IDX_W-1:0] ld_val,
    input  logic             data_wr,
    input  logic             data_rd,
    output logic [IDX_W-1:0] widx,
    output logic [IDX_W-1:0] ridx,
    output dir_e             dir,
    output chan_e            chan,
    output logic             store_en,
    output logic             fetch_ok
);
    dir_e             dir_q, dir_d;
    chan_e            chan_q, chan_d;
    logic [IDX_W-1:0] widx_q, widx_d, ridx_q, ridx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= DIR_WRITE;
            chan_q <= CH_RED;
            widx_q <= '0;
            ridx_q <= '0;
        end else begin
            dir_q  <= dir_d;
            chan_q <= chan_d;
            widx_q <= widx_d;
            ridx_q <= ridx_d;
        end
    end

    // next-state: index loads rewind, data accesses step
    always_comb begin
        dir_d  = dir_q;
        chan_d = chan_q;
        widx_d = widx_q;
        ridx_d = ridx_q;
        if (ld_widx) begin
            widx_d = ld_val;
            dir_d  = DIR_WRITE;
            chan_d = CH_RED;
        end else if (ld_ridx) begin
            ridx_d = ld_val;
            dir_d  = DIR_READ;
            chan_d = CH_RED;
        end else if (data_wr || data_rd) begin
            unique case (chan_q)
                CH_RED:   chan_d = CH_GREEN;
                CH_GREEN: chan_d = CH_BLUE;
                CH_BLUE: begin
                    chan_d = CH_RED;
                    if (data_wr) widx_d = widx_q + 1'b1;
                    else         ridx_d = ridx_q + 1'b1;
                end
                default:  chan_d = CH_RED;
            endcase
        end
    end

    // outputs
    always_comb begin
        widx     = widx_q;
        ridx     = ridx_q;
        dir      = dir_q;
        chan     = chan_q;
        store_en = data_wr && (dir_q == DIR_WRITE);
        fetch_ok = data_rd && (dir_q == DIR_READ);
    end
endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W-1:0]    widx,
    input  chan_e               wchan,
    input  logic [CH_W-1:0]     wval,
    input  logic [IDX_W-1:0]    ridx,
    input  chan_e               rchan,
    output logic [CH_W-1:0]     rval,
    input  logic [IDX_W-1:0]    pidx,
    output logic [NCH*CH_W-1:0] prgb
);
    localparam int DEPTH = 1 << IDX_W;

    logic [CH_W-1:0] lane_rd [NCH];

    // one storage lane per color channel
    for (genvar g = 0; g < NCH; g++) begin : g_lane
        logic [CH_W-1:0] cells [DEPTH];
        logic [CH_W-1:0] px_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
                px_q <= '0;
            end else begin
                if (we && (int'(wchan) == g)) cells[widx] <= wval;
                px_q <= cells[pidx];
            end
        end

        assign lane_rd[g] = cells[ridx];
        assign prgb[g*CH_W +: CH_W] = px_q;
    end

    always_comb begin
        unique case (rchan)
            CH_RED:   rval = lane_rd[0];
            CH_GREEN: rval = lane_rd[1];
            CH_BLUE:  rval = lane_rd[2];
            default:  rval = '0;
        endcase
    end
endmodule

// File: rtl/clut_port.sv
module clut_port
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [1:0]          host_sel,
    input  logic [DBUS_W-1:0]   host_wdata,
    output logic [DBUS_W-1:0]   host_rdata,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [NCH*CH_W-1:0] pix_rgb
);
    logic             rd_go;
    logic             ld_widx, ld_ridx, data_wr, data_rd;
    logic [IDX_W-1:0] wr_idx, rd_idx, mask_q;
    dir_e             cur_dir;
    chan_e            cur_chan;
    logic             store_en, fetch_ok;
    logic [CH_W-1:0]  fetch_val;

    // a write strobe wins over a simultaneous read strobe
    assign rd_go   = host_rd && !host_wr;
    assign ld_widx = host_wr && (host_sel == SEL_WIDX);
    assign ld_ridx = host_wr && (host_sel == SEL_RIDX);
    assign data_wr = host_wr && (host_sel == SEL_DATA);
    assign data_rd = rd_go   && (host_sel == SEL_DATA);

    clut_seq #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_widx  (ld_widx),
        .ld_ridx  (ld_ridx),
        .ld_val   (host_wdata[IDX_W-1:0]),
        .data_wr  (data_wr),
        .data_rd  (data_rd),
        .widx     (wr_idx),
        .ridx     (rd_idx),
        .dir      (cur_dir),
        .chan     (cur_chan),
        .store_en (store_en),
        .fetch_ok (fetch_ok)
    );

    clut_store #(.IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_en),
        .widx  (wr_idx),
        .wchan (cur_chan),
        .wval  (host_wdata[CH_W-1:0]),
        .ridx  (rd_idx),
        .rchan (cur_chan),
        .rval  (fetch_val),
        .pidx  (pix_idx & mask_q),
        .prgb  (pix_rgb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             mask_q <= '1;
        else if (host_wr && host_sel == SEL_MASK) mask_q <= host_wdata[IDX_W-1:0];
    end

    always_comb begin
        host_rdata = '0;
        if (rd_go) begin
            unique case (host_sel)
                SEL_WIDX: host_rdata = DBUS_W'(wr_idx);
                SEL_RIDX: host_rdata = DBUS_W'(rd_idx);
                SEL_DATA: host_rdata = fetch_ok ? DBUS_W'(fetch_val) : '0;
                SEL_MASK: host_rdata = DBUS_W'(mask_q);
                default:  host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/clut_port_chk.sv
module clut_port_chk
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [1:0]        host_sel,
    input logic [DBUS_W-1:0] host_wdata,
    input logic [DBUS_W-1:0] host_rdata,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [IDX_W-1:0]  rd_idx,
    input dir_e              dir,
    input chan_e             chan,
    input logic [IDX_W-1:0]  mask
);
    logic dacc;
    assign dacc = (host_wr || host_rd) && host_sel == SEL_DATA;

    a_r1_widx_load: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_WIDX) |=>
        (wr_idx == $past(host_wdata[IDX_W-1:0]) && dir == DIR_WRITE && chan == CH_RED));

    a_r2_ridx_load: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_RIDX) |=>
        (rd_idx == $past(host_wdata[IDX_W-1:0]) && dir == DIR_READ && chan == CH_RED));

    a_r3_idx_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && (host_sel == SEL_WIDX || host_sel == SEL_RIDX)) |=>
        ($stable(chan) && $stable(dir)));

    a_r6_red_to_green: assert property (@(posedge clk) disable iff (!rst_n)
        (dacc && chan == CH_RED) |=> chan == CH_GREEN);

    a_r6_green_to_blue: assert property (@(posedge clk) disable iff (!rst_n)
        (dacc && chan == CH_GREEN) |=> chan == CH_BLUE);

    a_r6_blue_to_red: assert property (@(posedge clk) disable iff (!rst_n)
        (dacc && chan == CH_BLUE) |=> chan == CH_RED);

    a_r6_widx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_DATA && chan == CH_BLUE) |=>
        wr_idx == IDX_W'($past(wr_idx) + 1'b1));

    a_r7_wrong_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_sel == SEL_DATA && dir == DIR_WRITE) |->
        host_rdata == '0);

    a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_MASK) |=> mask == $past(host_wdata[IDX_W-1:0]));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !host_rd) |=>
        ($stable(chan) && $stable(dir) && $stable(wr_idx) && $stable(rd_idx)));

    a_r10_no_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> host_rdata == '0);
endmodule

bind clut_port clut_port_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .wr_idx     (wr_idx),
    .rd_idx     (rd_idx),
    .dir        (cur_dir),
    .chan       (cur_chan),
    .mask       (mask_q)
);

// File: tb/sim_clut_port.sv
`timescale 1ns/1ps
module sim_clut_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic [7:0]  pix_idx = 8'd0;
    logic [17:0] pix_rgb;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state, built from the requirements
    logic [17:0] m_pal [256];
    int m_wr, m_rd, m_ch, m_mask;
    bit m_rdir;

    always #2.5 clk = ~clk;

    clut_port u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit is_wr);
        m_ch++;
        if (m_ch == 3) begin
            m_ch = 0;
            if (is_wr) m_wr = (m_wr + 1) % 256;
            else       m_rd = (m_rd + 1) % 256;
        end
    endtask

    task automatic do_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        case (s)
            2'd0: begin m_wr = d; m_rdir = 0; m_ch = 0; end
            2'd1: begin m_rd = d; m_rdir = 1; m_ch = 0; end
            2'd2: begin
                if (!m_rdir) m_pal[m_wr][m_ch*6 +: 6] = d[5:0];
                step(1);
            end
            default: m_mask = d;
        endcase
    endtask

    task automatic do_rd(input logic [1:0] s, input string req);
        int exp;
        int got;
        @(negedge clk);
        host_sel = s; host_rd = 1'b1;
        #1 got = host_rdata;
        case (s)
            2'd0: exp = m_wr;
            2'd1: exp = m_rd;
            2'd2: exp = m_rdir ? int'(m_pal[m_rd][m_ch*6 +: 6]) : 0;
            default: exp = m_mask;
        endcase
        check(req, got, exp);
        if (s == 2'd2) step(0);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic pix_sweep(input logic [7:0] msk);
        do_wr(2'd3, msk);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pix_idx = 8'(i);
            @(negedge clk);
            check("R9", int'(pix_rgb), int'(m_pal[i & m_mask]));
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) m_pal[i] = '0;
        m_wr = 0; m_rd = 0; m_ch = 0; m_rdir = 0; m_mask = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R10", int'(host_rdata), 0);
        check("R10", int'(pix_rgb), 0);

        // reset state through the host port
        do_rd(2'd0, "R10");
        do_rd(2'd1, "R10");
        do_rd(2'd3, "R8");
        do_rd(2'd2, "R10");

        // full table write with upper bits set, then wrap check
        do_wr(2'd0, 8'd0);
        for (int i = 0; i < 768; i++) do_wr(2'd2, {2'b10, 6'(i * 37 + 5)});
        do_rd(2'd0, "R6");
        check("R1", m_wr, 0);

        // full readback through the read index
        do_wr(2'd1, 8'd0);
        for (int i = 0; i < 768; i++) do_rd(2'd2, "R5");
        do_rd(2'd1, "R6");

        // index reads between data reads
        do_wr(2'd1, 8'd200);
        do_rd(2'd2, "R2");
        do_rd(2'd1, "R3");
        do_rd(2'd0, "R3");
        do_rd(2'd2, "R3");
        do_rd(2'd2, "R3");

        // single-channel write keeps the other channels
        do_wr(2'd0, 8'd17);
        do_wr(2'd2, 8'hFF);
        do_wr(2'd1, 8'd17);
        for (int i = 0; i < 3; i++) do_rd(2'd2, "R4");

        // accesses against the direction
        do_wr(2'd1, 8'd40);
        do_wr(2'd2, 8'h15);
        do_rd(2'd2, "R7");
        do_wr(2'd0, 8'd60);
        do_rd(2'd2, "R7");
        do_wr(2'd2, 8'h2A);
        do_wr(2'd1, 8'd60);
        for (int i = 0; i < 3; i++) do_rd(2'd2, "R7");
        do_wr(2'd1, 8'd40);
        for (int i = 0; i < 3; i++) do_rd(2'd2, "R7");
        do_wr(2'd0, 8'd255);
        do_wr(2'd1, 8'd5);
        for (int i = 0; i < 3; i++) do_wr(2'd2, 8'h3C);
        do_rd(2'd0, "R7");

        // simultaneous strobes: write wins, read is ignored
        do_wr(2'd1, 8'd0);
        @(negedge clk);
        host_sel = 2'd2; host_wdata = 8'h11; host_wr = 1'b1; host_rd = 1'b1;
        #1 check("R11", int'(host_rdata), 0);
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        step(1);
        do_rd(2'd2, "R11");

        // pixel mask and lookup
        do_wr(2'd3, 8'hA5);
        do_rd(2'd3, "R8");
        pix_sweep(8'hFF);
        pix_sweep(8'h0F);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule